// File: doc/BRIEF.md
# Round-Robin Shared Bus Fabric

This block is a shared bus that joins four bus masters to four slaves using Wishbone classic signalling. A master asks for the bus by raising CYC. A four-way round-robin arbiter gives the bus to one master at a time. The owner keeps the bus until it lowers CYC. While it owns the bus, its address, write data, write enable, byte selects and strobe go out on one set of shared slave-side wires. All steering is done with AND-OR multiplexers, with no three-state drivers. Address and data use separate wires.

Two address bits pick the target slave, which gives each slave a fixed window of eight words. Only that slave sees the strobe. The acknowledge and read data from that slave go back to the owning master and to no other master. The one-hot grant vector is brought out so the arbitration can be observed.

Top module: `rr_bus_fabric`

## Requirements
- R1: During and straight after reset the grant vector is zero and every slave strobe is low. The rotation starts so that, when all four masters request together, master 0 is served first.
- R2: When no master asserts CYC at a clock edge, the grant after that edge is zero, and all slave strobes and the shared CYC are low.
- R3: While the owning master keeps CYC high, the grant does not change, whatever the other masters request.
- R4: A new owner is chosen only at a clock edge where the bus is free, meaning there is no owner or the owner's CYC is low. The grant therefore changes one clock after CYC drops. The new owner is the first master holding CYC in ascending order with wrap-around (0,1,2,3,0…), starting just after the last owner. Masters not requesting are skipped.
- R5: The grant vector is one-hot or zero.
- R6: The shared slave-side address, write data, write enable, byte selects and CYC equal those of the owner. They are zero when there is no owner.
- R7: Slave j's strobe equals the owner's STB AND CYC when owner address bits [4:3] equal j. This maps slave 0..3 to word ranges 0x00–0x07, 0x08–0x0F, 0x10–0x17 and 0x18–0x1F. All other slave strobes are low. Address bits other than [4:3] do not affect the choice.
- R8: Only the owner receives an acknowledge, and it is taken from the decoded slave. Masters without the grant see ACK low. ACKs from slaves that are not selected are ignored.
- R9: The owner's read data is the decoded slave's read data. Masters without the grant see zero.
- R10: Address, write data and read data paths carry all 32 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc_i | input | 4 | Per-master bus cycle / request |
| m_stb_i | input | 4 | Per-master strobe |
| m_we_i | input | 4 | Per-master write enable |
| m_adr_i | input | 128 | Master addresses, 32 bits each, master 0 in bits [31:0] |
| m_dat_i | input | 128 | Master write data, 32 bits each |
| m_sel_i | input | 16 | Master byte selects, 4 bits each |
| m_ack_o | output | 4 | Per-master acknowledge |
| m_dat_o | output | 128 | Per-master read data, 32 bits each |
| s_cyc_o | output | 1 | Shared bus cycle to slaves |
| s_stb_o | output | 4 | Per-slave strobe |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | 32 | Shared address |
| s_dat_o | output | 32 | Shared write data |
| s_sel_o | output | 4 | Shared byte selects |
| s_ack_i | input | 4 | Per-slave acknowledge |
| s_dat_i | input | 128 | Slave read data, 32 bits each |
| grant_o | output | 4 | One-hot grant for observation |

## Verification
The assertions check these properties on every cycle:
- the grant is one-hot or zero;
- the grant stays put while its owner holds CYC;
- the grant clears when nobody requests;
- a newly granted master was requesting at the edge before;
- at most one slave strobe and one master ACK are active;
- the shared CYC is never active without a grant.

The order of rotation, the skipping of idle masters, the address decode including the ignored upper bits, and the routing of ACK and read data can only be shown by the bench's scenarios. There, a cycle-by-cycle reference model follows random masters and slaves.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  // Default geometry of the fabric
  localparam int unsigned RRB_MASTERS = 4;
  localparam int unsigned RRB_SLAVES  = 4;
  localparam int unsigned RRB_ADDR_W  = 32;
  localparam int unsigned RRB_DATA_W  = 32;
  // Lowest address bit of the slave-select field (eight words per slave)
  localparam int unsigned RRB_DEC_LSB = 3;
endpackage

// File: rtl/rrb_arbiter.sv
module rrb_arbiter #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N-1:0]  grant_q, grant_d;
  logic [IW-1:0] last_q, pick;
  logic          found, hold, upd_en;

  // Next-state: keep owner while it requests, else rotate from last owner
  always_comb begin
    hold  = |(grant_q & req);
    found = 1'b0;
    pick  = last_q;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= int'(N)) c = c - int'(N);
      if (!found && req[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
    grant_d = found ? ({{(N-1){1'b0}}, 1'b1} << pick) : '0;
    upd_en  = !hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(N - 1);
    end else if (upd_en) begin
      grant_q <= grant_d;
      if (found) last_q <= pick;
    end
  end

  assign grant = grant_q;

  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  a_r3_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant_q & req)) |=> $stable(grant_q));
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |=> (grant_q == '0));
  a_r4_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && !$stable(grant_q)) |-> (|(grant_q & $past(req))));
endmodule

// File: rtl/rrb_decoder.sv
module rrb_decoder #(
  parameter int unsigned NS      = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned DEC_LSB = 3,
  localparam int unsigned SB     = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] adr,
  input  logic          stb,
  output logic [SB-1:0] slv_idx,
  output logic [NS-1:0] slv_stb
);
  assign slv_idx = adr[DEC_LSB +: SB];

  for (genvar j = 0; j < int'(NS); j++) begin : g_sel
    assign slv_stb[j] = stb && (slv_idx == SB'(j));
  end

  a_r7_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_stb));
endmodule

// File: rtl/rrb_resp_mux.sv
module rrb_resp_mux #(
  parameter int unsigned NM = 4,
  parameter int unsigned NS = 4,
  parameter int unsigned DW = 32,
  localparam int unsigned SB = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NM-1:0]    grant,
  input  logic [SB-1:0]    slv_idx,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS*DW-1:0] s_dat,
  output logic [NM-1:0]    m_ack,
  output logic [NM*DW-1:0] m_dat
);
  logic          ack_sel;
  logic [DW-1:0] dat_sel;

  always_comb begin
    ack_sel = 1'b0;
    dat_sel = '0;
    for (int j = 0; j < int'(NS); j++) begin
      if (slv_idx == SB'(j)) begin
        ack_sel = s_ack[j];
        dat_sel = s_dat[j*DW +: DW];
      end
    end
  end

  for (genvar m = 0; m < int'(NM); m++) begin : g_ret
    assign m_ack[m]            = grant[m] & ack_sel;
    assign m_dat[m*DW +: DW]   = grant[m] ? dat_sel : '0;
  end
endmodule

// File: rtl/rr_bus_fabric.sv
module rr_bus_fabric
  import rrb_pkg::*;
#(
  parameter int unsigned NM      = RRB_MASTERS,
  parameter int unsigned NS      = RRB_SLAVES,
  parameter int unsigned AW      = RRB_ADDR_W,
  parameter int unsigned DW      = RRB_DATA_W,
  parameter int unsigned DEC_LSB = RRB_DEC_LSB,
  localparam int unsigned SW     = DW / 8,
  localparam int unsigned SB     = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NM-1:0]      m_cyc_i,
  input  logic [NM-1:0]      m_stb_i,
  input  logic [NM-1:0]      m_we_i,
  input  logic [NM*AW-1:0]   m_adr_i,
  input  logic [NM*DW-1:0]   m_dat_i,
  input  logic [NM*SW-1:0]   m_sel_i,
  output logic [NM-1:0]      m_ack_o,
  output logic [NM*DW-1:0]   m_dat_o,
  output logic               s_cyc_o,
  output logic [NS-1:0]      s_stb_o,
  output logic               s_we_o,
  output logic [AW-1:0]      s_adr_o,
  output logic [DW-1:0]      s_dat_o,
  output logic [SW-1:0]      s_sel_o,
  input  logic [NS-1:0]      s_ack_i,
  input  logic [NS*DW-1:0]   s_dat_i,
  output logic [NM-1:0]      grant_o
);
  logic [NM-1:0] grant;
  logic          own_cyc, own_stb, own_we;
  logic [AW-1:0] own_adr;
  logic [DW-1:0] own_dat;
  logic [SW-1:0] own_sel;
  logic [SB-1:0] slv_idx;

  rrb_arbiter #(.N(NM)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (m_cyc_i),
    .grant (grant)
  );

  // Request path: AND-OR multiplexer steered by the one-hot grant
  always_comb begin
    own_cyc = 1'b0;
    own_stb = 1'b0;
    own_we  = 1'b0;
    own_adr = '0;
    own_dat = '0;
    own_sel = '0;
    for (int m = 0; m < int'(NM); m++) begin
      if (grant[m]) begin
        own_cyc = m_cyc_i[m];
        own_stb = m_stb_i[m];
        own_we  = m_we_i[m];
        own_adr = m_adr_i[m*AW +: AW];
        own_dat = m_dat_i[m*DW +: DW];
        own_sel = m_sel_i[m*SW +: SW];
      end
    end
  end

  rrb_decoder #(.NS(NS), .AW(AW), .DEC_LSB(DEC_LSB)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .adr     (own_adr),
    .stb     (own_stb & own_cyc),
    .slv_idx (slv_idx),
    .slv_stb (s_stb_o)
  );

  rrb_resp_mux #(.NM(NM), .NS(NS), .DW(DW)) u_resp (
    .grant   (grant),
    .slv_idx (slv_idx),
    .s_ack   (s_ack_i),
    .s_dat   (s_dat_i),
    .m_ack   (m_ack_o),
    .m_dat   (m_dat_o)
  );

  assign s_cyc_o = own_cyc;
  assign s_we_o  = own_we;
  assign s_adr_o = own_adr;
  assign s_dat_o = own_dat;
  assign s_sel_o = own_sel;
  assign grant_o = grant;

  a_r8_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ack_o));
  a_r6_cyc_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    s_cyc_o |-> (|grant_o));
endmodule

// File: tb/tb_rr_bus_fabric.sv
`timescale 1ns/1ps
module tb_rr_bus_fabric;
  localparam int NM = 4, NS = 4, AW = 32, DW = 32, SW = 4;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rst_n;
  logic [NM-1:0]           m_cyc, m_stb, m_we, m_ack, grant;
  logic [NM-1:0][AW-1:0]   m_adr;
  logic [NM-1:0][DW-1:0]   m_dat, m_rdat;
  logic [NM-1:0][SW-1:0]   m_sel;
  logic                    s_cyc, s_we;
  logic [NS-1:0]           s_stb, s_ack;
  logic [AW-1:0]           s_adr;
  logic [DW-1:0]           s_wdat;
  logic [SW-1:0]           s_sel;
  logic [NS-1:0][DW-1:0]   s_rdat;

  rr_bus_fabric dut (
    .clk(clk), .rst_n(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we),
    .m_adr_i(m_adr), .m_dat_i(m_dat), .m_sel_i(m_sel),
    .m_ack_o(m_ack), .m_dat_o(m_rdat),
    .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we),
    .s_adr_o(s_adr), .s_dat_o(s_wdat), .s_sel_o(s_sel),
    .s_ack_i(s_ack), .s_dat_i(s_rdat), .grant_o(grant)
  );

  int errors = 0, checks = 0;
  int ref_owner = -1, ref_last = NM - 1;
  bit cmp_en = 0, rnd = 0, done = 0;
  int hold_left [NM];

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Behavioural reference: owner index and last owner, updated each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_owner = -1;
      ref_last  = NM - 1;
    end else if (!(ref_owner >= 0 && m_cyc[ref_owner])) begin
      int w;
      w = -1;
      for (int k = 1; k <= NM; k++) begin
        int c;
        c = (ref_last + k) % NM;
        if (w < 0 && m_cyc[c]) w = c;
      end
      ref_owner = w;
      if (w >= 0) ref_last = w;
    end
  end

  // Expected outputs, compared at every falling edge
  logic [NM-1:0]         e_grant, e_ack;
  logic [NS-1:0]         e_stb;
  logic [NM-1:0][DW-1:0] e_rdat;
  logic [AW-1:0]         e_adr;
  logic [DW-1:0]         e_wdat;
  logic [SW-1:0]         e_sel;
  logic                  e_we, e_cyc;

  always @(negedge clk) begin
    if (cmp_en) begin
      e_grant = '0; e_ack = '0; e_stb = '0; e_rdat = '0;
      e_adr = '0; e_wdat = '0; e_sel = '0; e_we = 1'b0; e_cyc = 1'b0;
      if (ref_owner >= 0) begin
        int k;
        k = int'(m_adr[ref_owner][4:3]);
        e_grant[ref_owner] = 1'b1;
        e_stb[k]           = m_cyc[ref_owner] & m_stb[ref_owner];
        e_adr              = m_adr[ref_owner];
        e_wdat             = m_dat[ref_owner];
        e_sel              = m_sel[ref_owner];
        e_we               = m_we[ref_owner];
        e_cyc              = m_cyc[ref_owner];
        e_ack[ref_owner]   = s_ack[k];
        e_rdat[ref_owner]  = s_rdat[k];
      end
      check("R4 grant follows rotation model", 128'(grant), 128'(e_grant));
      check("R5 grant one-hot or zero", 128'($countones(grant) <= 1), 128'(1));
      check("R7 slave strobes", 128'(s_stb), 128'(e_stb));
      check("R6 shared address", 128'(s_adr), 128'(e_adr));
      check("R6 shared write data", 128'(s_wdat), 128'(e_wdat));
      check("R6 shared we/sel/cyc", 128'({s_we, s_sel, s_cyc}), 128'({e_we, e_sel, e_cyc}));
      check("R8 master acks", 128'(m_ack), 128'(e_ack));
      check("R9 master read data", 128'(m_rdat), 128'(e_rdat));
    end
  end

  // Random masters and slaves
  always @(posedge clk) begin
    if (rnd) begin
      #2;
      for (int i = 0; i < NM; i++) begin
        if (m_cyc[i]) begin
          if (hold_left[i] == 0) begin
            m_cyc[i] = 1'b0;
            m_stb[i] = 1'b0;
          end else begin
            hold_left[i]--;
            m_stb[i] = 1'($urandom % 2);
            m_adr[i] = $urandom;
            m_dat[i] = $urandom;
            m_we[i]  = 1'($urandom % 2);
            m_sel[i] = 4'($urandom);
          end
        end else if ($urandom % 4 == 0) begin
          m_cyc[i]     = 1'b1;
          m_stb[i]     = 1'b1;
          hold_left[i] = int'($urandom % 6);
          m_adr[i]     = $urandom;
          m_dat[i]     = $urandom;
          m_we[i]      = 1'($urandom % 2);
          m_sel[i]     = 4'($urandom);
        end
      end
      s_ack = 4'($urandom);
      for (int j = 0; j < NS; j++) s_rdat[j] = $urandom;
    end
  end

  initial begin
    rst_n = 1'b0;
    m_cyc = '0; m_stb = '0; m_we = '0; m_adr = '0; m_dat = '0; m_sel = '0;
    s_ack = '1;
    for (int j = 0; j < NS; j++) s_rdat[j] = 32'hA5A5_0000 | 32'(j);
    for (int i = 0; i < NM; i++) hold_left[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 grant zero in reset", 128'(grant), 128'(0));
    check("R1 strobes low in reset", 128'(s_stb), 128'(0));
    @(posedge clk); #2 rst_n = 1'b1; cmp_en = 1;

    // All four request at once
    @(posedge clk); #2;
    for (int i = 0; i < NM; i++) begin
      m_cyc[i] = 1'b1; m_stb[i] = 1'b1; m_we[i] = 1'(i % 2);
      m_adr[i] = 32'hF000_0000 | 32'(i * 8 + i);
      m_dat[i] = 32'hA5A5_A5A0 + 32'(i);
      m_sel[i] = 4'hF;
    end
    @(negedge clk); check("R4 grant waits for the next edge", 128'(grant), 128'(0));
    @(negedge clk); check("R1 first grant to master 0", 128'(grant), 128'(4'b0001));
    check("R10 full 32-bit write data", 128'(s_wdat), 128'(32'hA5A5_A5A0));
    repeat (4) begin
      @(posedge clk); #2 m_stb[1] = ~m_stb[1];
      @(negedge clk); check("R3 owner keeps bus", 128'(grant), 128'(4'b0001));
    end
    m_stb[1] = 1'b1;

    // Rotation 0 -> 1 -> 2 -> 3 -> 0
    for (int j = 0; j < NM; j++) begin
      @(posedge clk); #2 m_cyc[j] = 1'b0;
      @(negedge clk); check("R4 grant unchanged in release clock", 128'(grant), 128'(1 << j));
      @(posedge clk); #2 m_cyc[j] = 1'b1;
      @(negedge clk); check("R4 rotation to next master", 128'(grant), 128'(1 << ((j + 1) % NM)));
    end

    // Skip a silent master: only 0 (owner) and 2 request
    @(posedge clk); #2 m_cyc = 4'b0101;
    @(posedge clk); #2 m_cyc[0] = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 master 1 skipped", 128'(grant), 128'(4'b0100));
    check("R7 address 0x12 selects slave 2", 128'(s_stb), 128'(4'b0100));

    // Partial decode ignores upper bits; ack/data routing
    @(posedge clk); #2 m_adr[2] = 32'h7FFF_FFF8; s_ack = 4'b0100;
    @(negedge clk);
    check("R7 bits [4:3]=3 select slave 3", 128'(s_stb), 128'(4'b1000));
    check("R8 unselected slave ack ignored", 128'(m_ack), 128'(0));
    check("R9 owner reads slave 3", 128'(m_rdat[2]), 128'(32'hA5A5_0003));
    check("R9 ungranted master reads zero", 128'(m_rdat[0]), 128'(0));
    @(posedge clk); #2 s_ack = 4'b1000;
    @(negedge clk);
    check("R8 ack only to owner", 128'(m_ack), 128'(4'b0100));

    // Idle bus
    @(posedge clk); #2 m_cyc = '0; m_stb = '0;
    @(posedge clk); @(negedge clk);
    check("R2 no grant when idle", 128'(grant), 128'(0));
    check("R2 no strobe or cycle when idle", 128'({s_stb, s_cyc}), 128'(0));

    // Random traffic against the model
    rnd = 1;
    repeat (3000) @(posedge clk);
    @(negedge clk);
    rnd = 0; cmp_en = 0; done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule